// File: doc/BRIEF.md
# Sleep and Wake Supervisor

This block is the always-powered supervisor that puts a fast processing core into standby and brings it back. It runs from a slow oscillator clock of roughly 4 kHz. In standby it keeps a timeout counter running and watches two external event pins: an intercom request and a hook/flip switch. Each pin has its own selectable active edge. When any of these sources fires, the block runs a staged power-up sequence. It raises the DC power-control output first, then releases the core's I/O three-state enable, and last raises the operate indication.

A small register port in the fast clock domain lets the host request standby and read the wake status. Standby is a two-step sequence: the operate bit must already be set before a standby command is honoured. The cause of each wake-up is recorded as a sticky bit. Pin activity while the core is awake does not change state; it only sets poll bits. Every signal crossing between the two clock domains passes through a synchronizer. The standby request is a toggle that the slow domain acknowledges back.

The host port has two registers, selected by `host_addr`. Address 0 is control: bit 0 is operate, bit 1 is standby command (write-only, reads 0), bit 2 is the intercom edge select and bit 3 is the flip-switch edge select (1 = rising, 0 = falling). Address 1 is status: bit 0 is the timer wake reason, bit 1 the intercom wake reason, bit 2 the flip-switch wake reason, bit 3 the intercom-while-awake flag, bit 4 the flip-while-awake flag and bit 5 the awake indication (read-only).

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the block is awake: `pwr_en`, `io_oe` and `core_run` are 1. Status reads 0x20 and control reads 0x00.
- R2: While asleep with no pin edge, the block wakes after exactly TIMEOUT_TICKS slow clock cycles with `pwr_en` low, and sets status bit 0. The count restarts from zero on every entry into sleep.
- R3: While asleep, an edge on `icm_pin` wakes the block within a few slow cycles and sets status bit 1. The edge is the one selected by control bit 2 (1 = rising, 0 = falling).
- R4: While asleep, an edge on `flip_pin` wakes the block within a few slow cycles and sets status bit 2. The edge is the one selected by control bit 3 (1 = rising, 0 = falling).
- R5: A write of control bit 1 enters standby only if control bit 0 was already 1 before that write and the block is awake. A standby write with operate clear, or with operate set in the same write, leaves the block awake. An accepted standby clears control bit 0.
- R6: While asleep, `pwr_en`, `io_oe` and `core_run` are all 0.
- R7: On wake-up, `pwr_en` rises first. `io_oe` rises 2 slow cycles after `pwr_en`, and `core_run` rises 1 slow cycle after `io_oe`.
- R8: While awake, an active edge on `icm_pin` or `flip_pin` leaves the outputs unchanged. It sets status bit 3 (intercom) or bit 4 (flip switch).
- R9: Status bits 0 to 4 stay set until the host writes a 1 to that bit at address 1. Bits written 0 are unchanged. A new event in the same fast cycle as the clear wins over the clear.
- R10: When several wake sources fire in the same slow cycle, all of their reason bits are set.
- R11: Status bit 5 reads 1 while the core is running and 0 while it is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Host port clock |
| slow_clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both domains |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 control, 1 status |
| host_wdata | input | 6 | Write data |
| host_rdata | output | 6 | Read data of the selected register |
| icm_pin | input | 1 | Intercom request pin, asynchronous |
| flip_pin | input | 1 | Hook/flip switch pin, asynchronous |
| pwr_en | output | 1 | DC power-control output |
| io_oe | output | 1 | Core I/O drive enable; 0 means three-stated |
| core_run | output | 1 | Operate (1) / standby (0) indication to the core |

## Verification
The wake function is exercised with five patterns: a pure timeout, and each pin with a rising and with a falling active edge. This shows that each source sets only its own reason bit and that the edge select really inverts detection. The timeout run measures the sleep length in slow cycles, which separates a correct terminal count from an off-by-one. Every wake-up also samples the three outputs on four consecutive slow cycles, so a wrong stage order or stage gap is caught. Directed runs cover standby rejection with operate clear or set in the same write, pin edges while awake, per-bit clearing of status, and two pins falling together during sleep. The fast and slow clocks run at an unrelated ratio.

// File: rtl/swc_pkg.sv
// Shared definitions for the sleep/wake supervisor.
// Assumes a 1-bit register address and a 6-bit register data path.
package swc_pkg;
    localparam int DATA_W = 6;

    // register addresses
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // control register bit positions
    localparam int CTL_OPERATE = 0;
    localparam int CTL_STANDBY = 1;
    localparam int CTL_ICM_RISE = 2;
    localparam int CTL_FLP_RISE = 3;

    // wake reason bit positions (status bits 2:0)
    localparam int RSN_TMR = 0;
    localparam int RSN_ICM = 1;
    localparam int RSN_FLP = 2;

    // slow-domain power sequence
    typedef enum logic [2:0] {
        ST_SLEEP = 3'd0,
        ST_PWR1  = 3'd1,
        ST_PWR2  = 3'd2,
        ST_IOON  = 3'd3,
        ST_RUN   = 3'd4
    } pwr_state_t;
endpackage

// File: rtl/swc_sync.sv
// Multi-stage synchronizer for level or toggle signals.
// Assumes each bit is independent (toggles or quasi-static levels only).
module swc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_edge.sv
// Per-pin edge detector with a selectable active edge.
// Assumes pin_s is already synchronized to clk.
module swc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_s,
    input  logic [N-1:0] rise_sel,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev_q;

    // remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s;
    end

    for (genvar g = 0; g < N; g++) begin : g_pin
        // one-cycle pulse on the selected edge
        assign hit[g] = rise_sel[g] ? (pin_s[g] & ~prev_q[g])
                                    : (~pin_s[g] & prev_q[g]);
    end
endmodule

// File: rtl/swc_seq.sv
// Slow-domain sleep/wake sequencer: timeout counter, wake decision,
// staged power-up and event toggles toward the fast domain.
// Assumes sby_req is a synchronized toggle and hit a one-cycle pulse per pin.
module swc_seq
    import swc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hit,        // [0] intercom, [1] flip switch
    input  logic       sby_req,
    output logic       sby_ack,
    output logic [2:0] wake_tgl,   // indexed by RSN_*
    output logic [1:0] evt_tgl,    // awake-time pin activity
    output logic       pwr_en,
    output logic       io_oe,
    output logic       core_run
);
    localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_TICKS - 1);

    pwr_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tmr_hit;

    assign tmr_hit = (cnt_q == CNT_LAST);

    // state transitions, sleep timer and toggle bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            sby_ack  <= 1'b0;
            wake_tgl <= '0;
            evt_tgl  <= '0;
        end else begin
            if (state_q != ST_SLEEP) evt_tgl <= evt_tgl ^ hit;
            case (state_q)
                ST_SLEEP: begin
                    if (tmr_hit || (|hit)) begin
                        state_q  <= ST_PWR1;
                        wake_tgl <= wake_tgl ^ {hit[1], hit[0], tmr_hit};
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PWR1: state_q <= ST_PWR2;
                ST_PWR2: state_q <= ST_IOON;
                ST_IOON: state_q <= ST_RUN;
                ST_RUN: begin
                    if (sby_req != sby_ack) begin
                        sby_ack <= sby_req;
                        state_q <= ST_SLEEP;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // output stages decoded from the sequence state
    always_comb begin
        pwr_en   = (state_q != ST_SLEEP);
        io_oe    = (state_q == ST_IOON) || (state_q == ST_RUN);
        core_run = (state_q == ST_RUN);
    end
endmodule

// File: rtl/sleep_wake_ctrl.sv
// Sleep/wake supervisor top: fast-domain host registers, clock-domain
// crossings and the slow-domain sequencer.
// Assumes rst_n is held low for several cycles of both clocks.
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 8192,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              fast_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              icm_pin,
    input  logic              flip_pin,
    output logic              pwr_en,
    output logic              io_oe,
    output logic              core_run
);
    // fast-domain registers
    logic       operate_q, icm_rise_q, flp_rise_q, req_tgl_q;
    logic [2:0] wake_seen_q, reason_q;
    logic [1:0] evt_seen_q, evt_q;

    // crossing signals
    logic [4:0] s_in, s_out;
    logic [6:0] f_in, f_out;
    logic       sby_ack, ack_s, awake_s;
    logic [2:0] wake_tgl, wake_s;
    logic [1:0] evt_tgl, evt_s, hit;

    // fast-domain decode
    logic       wr_ctrl, wr_stat, pending, accept;
    logic [2:0] rsn_clr, rsn_new;
    logic [1:0] evt_clr, evt_new;

    // slow side: synchronize host config, request and pins
    assign s_in = {flip_pin, icm_pin, flp_rise_q, icm_rise_q, req_tgl_q};
    swc_sync #(.WIDTH(5), .STAGES(SYNC_STAGES)) u_sync_slow (
        .clk(slow_clk), .rst_n(rst_n), .d(s_in), .q(s_out)
    );

    swc_edge #(.N(2)) u_edge (
        .clk(slow_clk), .rst_n(rst_n),
        .pin_s(s_out[4:3]), .rise_sel(s_out[2:1]), .hit(hit)
    );

    swc_seq #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_seq (
        .clk(slow_clk), .rst_n(rst_n), .hit(hit), .sby_req(s_out[0]),
        .sby_ack(sby_ack), .wake_tgl(wake_tgl), .evt_tgl(evt_tgl),
        .pwr_en(pwr_en), .io_oe(io_oe), .core_run(core_run)
    );

    // fast side: synchronize acknowledge, event toggles and run state
    assign f_in = {core_run, evt_tgl, wake_tgl, sby_ack};
    swc_sync #(.WIDTH(7), .STAGES(SYNC_STAGES)) u_sync_fast (
        .clk(fast_clk), .rst_n(rst_n), .d(f_in), .q(f_out)
    );
    assign ack_s   = f_out[0];
    assign wake_s  = f_out[3:1];
    assign evt_s   = f_out[5:4];
    assign awake_s = f_out[6];

    // write decode, standby acceptance and event detection
    always_comb begin
        wr_ctrl = host_we && (host_addr == ADDR_CTRL);
        wr_stat = host_we && (host_addr == ADDR_STAT);
        pending = (req_tgl_q != ack_s);
        accept  = wr_ctrl && host_wdata[CTL_STANDBY] && operate_q
                  && awake_s && !pending;
        rsn_clr = wr_stat ? host_wdata[2:0] : 3'b000;
        evt_clr = wr_stat ? host_wdata[4:3] : 2'b00;
        rsn_new = wake_s ^ wake_seen_q;
        evt_new = evt_s ^ evt_seen_q;
    end

    // control register and standby request toggle
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            operate_q  <= 1'b0;
            icm_rise_q <= 1'b0;
            flp_rise_q <= 1'b0;
            req_tgl_q  <= 1'b0;
        end else if (wr_ctrl) begin
            icm_rise_q <= host_wdata[CTL_ICM_RISE];
            flp_rise_q <= host_wdata[CTL_FLP_RISE];
            operate_q  <= accept ? 1'b0 : host_wdata[CTL_OPERATE];
            if (accept) req_tgl_q <= ~req_tgl_q;
        end
    end

    // sticky status bits: new events win over write-one-to-clear
    always_ff @(posedge fast_clk) begin
        if (!rst_n) begin
            wake_seen_q <= '0;
            evt_seen_q  <= '0;
            reason_q    <= '0;
            evt_q       <= '0;
        end else begin
            wake_seen_q <= wake_s;
            evt_seen_q  <= evt_s;
            reason_q    <= (reason_q & ~rsn_clr) | rsn_new;
            evt_q       <= (evt_q & ~evt_clr) | evt_new;
        end
    end

    // read mux
    always_comb begin
        if (host_addr == ADDR_CTRL)
            host_rdata = {2'b00, flp_rise_q, icm_rise_q, 1'b0, operate_q};
        else
            host_rdata = {awake_s, evt_q, reason_q};
    end
endmodule

// File: rtl/swc_chk.sv
// Assertion checker for sleep_wake_ctrl, attached with bind.
// Assumes reason_q is the top's sticky wake-reason register.
module swc_chk #(
    parameter int TIMEOUT_TICKS = 8192
) (
    input logic       fast_clk,
    input logic       slow_clk,
    input logic       rst_n,
    input logic       host_we,
    input logic       host_addr,
    input logic [5:0] host_wdata,
    input logic [2:0] reason_q,
    input logic       pwr_en,
    input logic       io_oe,
    input logic       core_run
);
    int         off_ticks;
    logic [2:0] clr_c;

    // count slow cycles spent with power off
    always_ff @(posedge slow_clk) begin
        if (!rst_n || pwr_en) off_ticks <= 0;
        else                  off_ticks <= off_ticks + 1;
    end

    assign clr_c = (host_we && host_addr) ? host_wdata[2:0] : 3'b000;

    AST_SLEEP_DARK: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !pwr_en |-> (!io_oe && !core_run)); // R6
    AST_IO_AFTER_PWR: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(io_oe) |-> ($past(pwr_en, 1) && $past(pwr_en, 2))); // R7
    AST_RUN_AFTER_IO: assert property (@(posedge slow_clk) disable iff (!rst_n)
        $rose(core_run) |-> $past(io_oe)); // R7
    AST_TIMEOUT_BOUND: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !pwr_en |-> (off_ticks < TIMEOUT_TICKS)); // R2
    AST_REASON_STICKY: assert property (@(posedge fast_clk) disable iff (!rst_n)
        ((~reason_q & $past(reason_q) & ~$past(clr_c)) == 3'b000)); // R9
endmodule

bind sleep_wake_ctrl swc_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .fast_clk(fast_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .reason_q(reason_q), .pwr_en(pwr_en), .io_oe(io_oe), .core_run(core_run)
);

// File: tb/tb_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_wake_ctrl;
    localparam int TO = 40;

    logic       fast_clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic       host_we = 1'b0, host_addr = 1'b0;
    logic [5:0] host_wdata = '0;
    logic [5:0] host_rdata;
    logic       icm_pin = 1'b0, flip_pin = 1'b0;
    logic       pwr_en, io_oe, core_run;
    int         nchk = 0, nerr = 0;
    bit         done = 1'b0;

    sleep_wake_ctrl #(.TIMEOUT_TICKS(TO)) dut (.*);

    always #4 fast_clk = ~fast_clk;
    always #37 slow_clk = ~slow_clk;

    // vector: {source(0 timer,1 intercom,2 flip), rising, expected reason}
    localparam logic [5:0] VEC [5] = '{
        {2'd0, 1'b0, 3'b001}, {2'd1, 1'b1, 3'b010}, {2'd1, 1'b0, 3'b010},
        {2'd2, 1'b1, 3'b100}, {2'd2, 1'b0, 3'b100}
    };

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [5:0] d);
        @(negedge fast_clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge fast_clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [5:0] d);
        @(negedge fast_clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge slow_clk);
    endtask

    // count slow negedges until pwr_en equals lvl, bounded
    task automatic wait_pwr(input logic lvl, input int lim, output int n);
        n = 0;
        @(negedge slow_clk);
        while (pwr_en != lvl && n < lim) begin
            n++;
            @(negedge slow_clk);
        end
    endtask

    // sample the staged power-up starting at the first negedge with pwr_en high
    task automatic seq_check();
        logic [2:0] s [4];
        for (int k = 0; k < 4; k++) begin
            s[k] = {pwr_en, io_oe, core_run};
            if (k < 3) @(negedge slow_clk);
        end
        chk("R7 stage0", s[0], 3'b100);
        chk("R7 stage1", s[1], 3'b100);
        chk("R7 stage2", s[2], 3'b110);
        chk("R7 stage3", s[3], 3'b111);
    endtask

    initial begin
        logic [5:0] d;
        int n;
        repeat (100) @(negedge fast_clk);
        rst_n = 1'b1;
        ticks(6);

        // reset state (R1, R11)
        chk("R1 outputs", {pwr_en, io_oe, core_run}, 3'b111);
        rd(1'b1, d); chk("R1 status", d, 6'h20);
        rd(1'b0, d); chk("R1 ctrl", d, 6'h00);

        // R5: standby without prior operate is rejected
        wr(1'b0, 6'h02); ticks(12);
        chk("R5 reject no operate", {pwr_en, core_run}, 2'b11);
        wr(1'b0, 6'h03); ticks(12);
        chk("R5 reject same write", {pwr_en, core_run}, 2'b11);
        rd(1'b0, d); chk("R5 operate held", d[0], 1);
        wr(1'b0, 6'h03);
        wait_pwr(1'b0, 20, n);
        chk("R5 accepted", pwr_en, 0);
        chk("R6 asleep outputs", {io_oe, core_run}, 2'b00);
        rd(1'b0, d); chk("R5 operate cleared", d[0], 0);
        ticks(4); rd(1'b1, d); chk("R11 asleep flag", d[5], 0);
        wait_pwr(1'b1, 2 * TO, n);

        // main loop over wake sources and edge polarities
        for (int v = 0; v < 5; v++) begin
            logic [1:0] src;
            logic       rise;
            logic [2:0] exp_r;
            logic [5:0] cfg;
            {src, rise, exp_r} = VEC[v];
            icm_pin  = (src == 2'd1) && !rise;
            flip_pin = (src == 2'd2) && !rise;
            cfg = {2'b00, (src == 2'd2) ? rise : 1'b1,
                   (src == 2'd1) ? rise : 1'b1, 2'b01};
            wr(1'b0, cfg); ticks(8);
            wr(1'b1, 6'h1F);
            wr(1'b0, cfg | 6'h02);
            wait_pwr(1'b0, 20, n);
            chk("R6 asleep", {pwr_en, io_oe, core_run}, 3'b000);
            if (src == 2'd0) begin
                n = 0;
                while (pwr_en == 1'b0 && n < 2 * TO) begin
                    n++;
                    @(negedge slow_clk);
                end
                chk("R2 sleep length", n, TO);
            end else begin
                ticks(3);
                if (src == 2'd1) icm_pin = rise; else flip_pin = rise;
                wait_pwr(1'b1, 12, n);
                chk(src == 2'd1 ? "R3 pin wake" : "R4 pin wake", pwr_en, 1);
            end
            seq_check();
            ticks(6);
            rd(1'b1, d);
            chk(src == 2'd0 ? "R2 reason" : (src == 2'd1 ? "R3 reason" : "R4 reason"),
                d[2:0], exp_r);
            chk("R11 awake flag", d[5], 1);
        end

        // R8: pin edges while awake only set poll bits
        icm_pin = 1'b0; flip_pin = 1'b0;
        wr(1'b0, 6'h0C); ticks(8);
        wr(1'b1, 6'h1F);
        icm_pin = 1'b1; ticks(8);
        chk("R8 state kept", {pwr_en, io_oe, core_run}, 3'b111);
        flip_pin = 1'b1; ticks(8);
        rd(1'b1, d); chk("R8 poll bits", d, 6'h38);

        // R9: per-bit write-one-to-clear
        wr(1'b1, 6'h08); rd(1'b1, d); chk("R9 clear bit3", d, 6'h30);
        wr(1'b1, 6'h00); rd(1'b1, d); chk("R9 zero write", d, 6'h30);
        wr(1'b1, 6'h10); rd(1'b1, d); chk("R9 clear bit4", d, 6'h20);

        // R10: both pins fall in the same slow cycle while asleep
        wr(1'b0, 6'h01); ticks(8);
        wr(1'b1, 6'h1F);
        wr(1'b0, 6'h03);
        wait_pwr(1'b0, 20, n);
        ticks(3);
        @(negedge slow_clk);
        icm_pin = 1'b0; flip_pin = 1'b0;
        wait_pwr(1'b1, 12, n);
        ticks(8);
        rd(1'b1, d); chk("R10 both reasons", d[2:0], 3'b110);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge fast_clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule